// File: doc/BRIEF.md
# Serial Link Packet Header Framer

This block sits behind the receive FIFO of a serial peripheral link between two redundant controllers. It consumes 16-bit words one at a time. The first word of each packet is a header. The header carries an even-parity bit, an 8-bit packet type and a 4-bit payload count. The framer checks the header. It then hands out each following payload word together with the packet type and the word's position in the packet, and it marks the end of the packet. A header word of all zeros is a filler word, which the far end sends only to supply clocks. The framer drops it silently.

A header with broken parity, or a type that differs from the type software expects, marks the link as corrupt. The framer raises a one-cycle error pulse and enters a halted state. In that state it requests a reset of the receive channel. It then ignores every incoming word until a resync pulse returns it to header hunting. Two saturating 16-bit counters record the completed packets and the rejected headers.

The state machine has three states:

- `ST_HDR`: waiting for a header.
- `ST_PAY`: collecting payload words.
- `ST_HALT`: reset requested, input ignored.

Its transitions are:

- `ST_HDR` stays in `ST_HDR` on a filler word, on a valid header with a zero count, and on an idle cycle.
- `ST_HDR` goes to `ST_PAY` on a valid header with a non-zero count.
- `ST_HDR` goes to `ST_HALT` on a parity or type fault.
- `ST_PAY` goes to `ST_HDR` on the last payload word.
- `ST_HALT` goes to `ST_HDR` on `resync`.

Top module: `spi_hdr_framer`

## Requirements
- R1: After reset, `out_valid`, `pkt_done`, `err_parity`, `err_type` and `chan_reset_req` are low, both counters read 0, and the block waits for a header.
- R2: The header layout is:
  - bit 15: parity
  - bits 14:7: type
  - bits 6:3: payload count
  - bits 2:0: ignored

  The XOR of all 16 bits must be 0. A non-zero header that fails this test gives a one-cycle `err_parity` pulse in the cycle after the word, and increments `bad_count`. `chan_reset_req` goes high in that same cycle. Parity is judged before type, so a header with both faults reports only `err_parity`.
- R3: A word of 0x0000 received while waiting for a header produces no output, no error and no counter change, and the next word is still treated as a header.
- R4: A header with good parity whose type differs from `exp_type` gives a one-cycle `err_type` pulse, increments `bad_count`, and raises `chan_reset_req`.
- R5: After a valid header with count N > 0, the next N accepted words are each output one cycle after their arrival, with `out_valid` high, `out_type` equal to the header type and `out_index` running 0 to N-1. A payload word of 0x0000 is delivered like any other word.
- R6: `pkt_done` is high in the same cycle as the last payload output, `good_count` increments, and the following word is treated as a header.
- R7: A valid header with count 0 gives a `pkt_done` pulse with `out_valid` low in the cycle after it, and increments `good_count`.
- R8: While `chan_reset_req` is high, incoming words produce no output and change no counter. A `resync` pulse clears `chan_reset_req` at the next edge and restores header hunting. `resync` has no effect in any other state.
- R9: Both counters stop at 65535.
- R10: Words are consumed only in cycles where `in_valid` is high, so idle gaps inside a packet do not advance the payload index.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | A word is present on `in_word` this cycle |
| in_word | input | 16 | Received word |
| exp_type | input | 8 | Packet type the receiver accepts |
| resync | input | 1 | Leave the halted state |
| out_valid | output | 1 | Payload word valid |
| out_word | output | 16 | Payload word |
| out_type | output | 8 | Type of the packet the word belongs to |
| out_index | output | 4 | Position of the word in its packet |
| pkt_done | output | 1 | Packet completed |
| err_parity | output | 1 | Header parity fault pulse |
| err_type | output | 1 | Header type fault pulse |
| chan_reset_req | output | 1 | Channel reset requested (halted) |
| good_count | output | 16 | Completed packets, saturating |
| bad_count | output | 16 | Rejected headers, saturating |

## Verification
The bench sends a filler word straight before a real header. A design that treated the filler as a header would raise a parity or type fault or open a phantom packet. It also sends a header with both faults, so that checking type before parity shows up as the wrong pulse. Payloads include a zero word, idle gaps, a full count of 15 and a `resync` pulse mid-packet, which catch an index that slips, a payload zero mistaken for filler, or a stray resync that aborts the packet. A valid header sent while halted must leave the outputs and counters untouched. A long run of header-only packets then drives `good_count` into saturation, where a counter that wrapped would read a small value.

// File: rtl/hdr_pkg.sv
package hdr_pkg;
    typedef enum logic [1:0] {
        ST_HDR  = 2'd0,
        ST_PAY  = 2'd1,
        ST_HALT = 2'd2
    } fr_state_t;
endpackage

// File: rtl/hdr_decode.sv
module hdr_decode #(
    parameter int WORD_W = 16,
    parameter int TYPE_W = 8,
    parameter int LEN_W  = 4
) (
    input  logic [WORD_W-1:0] word,
    output logic              par_ok,
    output logic              is_filler,
    output logic [TYPE_W-1:0] typ,
    output logic [LEN_W-1:0]  len
);
    localparam int TYPE_HI = WORD_W - 2;
    localparam int LEN_HI  = TYPE_HI - TYPE_W;

    always_comb begin
        par_ok    = ~(^word);
        is_filler = (word == '0);
        typ       = word[TYPE_HI -: TYPE_W];
        len       = word[LEN_HI -: LEN_W];
    end
endmodule

// File: rtl/sat_counter.sv
module sat_counter #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         inc,
    output logic [W-1:0] count
);
    localparam logic [W-1:0] TOP = '1;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            count <= '0;
        else if (inc && count != TOP)
            count <= count + 1'b1;
    end

    AST_SAT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (count == TOP) |=> (count == TOP)); // R9
endmodule

// File: rtl/spi_hdr_framer.sv
module spi_hdr_framer
    import hdr_pkg::*;
#(
    parameter int WORD_W = 16,
    parameter int TYPE_W = 8,
    parameter int LEN_W  = 4,
    parameter int CNT_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [WORD_W-1:0] in_word,
    input  logic [TYPE_W-1:0] exp_type,
    input  logic              resync,
    output logic              out_valid,
    output logic [WORD_W-1:0] out_word,
    output logic [TYPE_W-1:0] out_type,
    output logic [LEN_W-1:0]  out_index,
    output logic              pkt_done,
    output logic              err_parity,
    output logic              err_type,
    output logic              chan_reset_req,
    output logic [CNT_W-1:0]  good_count,
    output logic [CNT_W-1:0]  bad_count
);
    localparam logic [LEN_W-1:0] LEN_ONE = LEN_W'(1);

    fr_state_t         state_q, state_d;
    logic [LEN_W-1:0]  len_q, len_d, idx_q, idx_d;
    logic [TYPE_W-1:0] typ_q, typ_d;
    logic              par_ok, is_filler;
    logic [TYPE_W-1:0] hdr_typ;
    logic [LEN_W-1:0]  hdr_len;
    logic              take_pay, done_c, perr_c, terr_c;

    hdr_decode #(.WORD_W(WORD_W), .TYPE_W(TYPE_W), .LEN_W(LEN_W)) u_dec (
        .word(in_word), .par_ok(par_ok), .is_filler(is_filler),
        .typ(hdr_typ), .len(hdr_len)
    );

    always_comb begin
        state_d  = state_q;
        len_d    = len_q;
        idx_d    = idx_q;
        typ_d    = typ_q;
        take_pay = 1'b0;
        done_c   = 1'b0;
        perr_c   = 1'b0;
        terr_c   = 1'b0;
        unique case (state_q)
            ST_HDR: begin
                if (in_valid && !is_filler) begin
                    if (!par_ok) begin
                        perr_c  = 1'b1;
                        state_d = ST_HALT;
                    end else if (hdr_typ != exp_type) begin
                        terr_c  = 1'b1;
                        state_d = ST_HALT;
                    end else if (hdr_len == '0) begin
                        done_c  = 1'b1;
                    end else begin
                        state_d = ST_PAY;
                        len_d   = hdr_len;
                        typ_d   = hdr_typ;
                        idx_d   = '0;
                    end
                end
            end
            ST_PAY: begin
                if (in_valid) begin
                    take_pay = 1'b1;
                    idx_d    = idx_q + LEN_ONE;
                    if (idx_q == len_q - LEN_ONE) begin
                        done_c  = 1'b1;
                        state_d = ST_HDR;
                    end
                end
            end
            ST_HALT: begin
                if (resync)
                    state_d = ST_HDR;
            end
            default: state_d = ST_HDR;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_HDR;
            len_q   <= '0;
            idx_q   <= '0;
            typ_q   <= '0;
        end else begin
            state_q <= state_d;
            len_q   <= len_d;
            idx_q   <= idx_d;
            typ_q   <= typ_d;
        end
    end

    // registered outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_valid  <= 1'b0;
            out_word   <= '0;
            out_type   <= '0;
            out_index  <= '0;
            pkt_done   <= 1'b0;
            err_parity <= 1'b0;
            err_type   <= 1'b0;
        end else begin
            out_valid  <= take_pay;
            pkt_done   <= done_c;
            err_parity <= perr_c;
            err_type   <= terr_c;
            if (take_pay) begin
                out_word  <= in_word;
                out_type  <= typ_q;
                out_index <= idx_q;
            end
        end
    end

    assign chan_reset_req = (state_q == ST_HALT);

    sat_counter #(.W(CNT_W)) u_good (
        .clk(clk), .rst_n(rst_n), .inc(done_c), .count(good_count)
    );
    sat_counter #(.W(CNT_W)) u_bad (
        .clk(clk), .rst_n(rst_n), .inc(perr_c | terr_c), .count(bad_count)
    );

    AST_ERR_HALTS: assert property (@(posedge clk) disable iff (!rst_n)
        (err_parity || err_type) |-> chan_reset_req); // R4
    AST_ONE_FAULT: assert property (@(posedge clk) disable iff (!rst_n)
        !(err_parity && err_type)); // R2
    AST_HALT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (chan_reset_req && !resync) |=> chan_reset_req); // R8
    AST_HALT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        chan_reset_req |=> !(out_valid || pkt_done)); // R8
    AST_FILLER_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_HDR && in_valid && in_word == '0)
        |=> !(out_valid || pkt_done || err_parity || err_type)); // R3
    AST_INDEX_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !pkt_done) |=>
        (!out_valid || out_index == LEN_W'($past(out_index) + LEN_ONE))); // R5
endmodule

// File: tb/spi_hdr_framer_test.sv
module spi_hdr_framer_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [15:0] in_word = '0;
    logic [7:0]  exp_type = 8'hA5;
    logic        resync = 1'b0;
    logic        out_valid, pkt_done, err_parity, err_type, chan_reset_req;
    logic [15:0] out_word, good_count, bad_count;
    logic [7:0]  out_type;
    logic [3:0]  out_index;

    int n_checks = 0;
    int n_errors = 0;
    int exp_good = 0;
    int exp_bad  = 0;

    typedef struct packed {
        logic        v, d, pe, te;
        logic [15:0] w;
        logic [7:0]  t;
        logic [3:0]  i;
    } ev_t;
    ev_t exp_q[$];

    always #10 clk = ~clk;

    spi_hdr_framer uut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_word(in_word),
        .exp_type(exp_type), .resync(resync), .out_valid(out_valid),
        .out_word(out_word), .out_type(out_type), .out_index(out_index),
        .pkt_done(pkt_done), .err_parity(err_parity), .err_type(err_type),
        .chan_reset_req(chan_reset_req), .good_count(good_count),
        .bad_count(bad_count)
    );

    function automatic logic [15:0] mk_hdr(input logic [7:0] t, input logic [3:0] n);
        return {^{t, n}, t, n, 3'b000};
    endfunction

    function automatic ev_t ev(input logic v, input logic d, input logic pe,
                               input logic te, input logic [15:0] w,
                               input logic [7:0] t, input logic [3:0] i);
        ev_t e;
        e.v = v; e.d = d; e.pe = pe; e.te = te; e.w = w; e.t = t; e.i = i;
        return e;
    endfunction

    // monitor / scoreboard
    always @(negedge clk) begin
        if (rst_n && (out_valid || pkt_done || err_parity || err_type)) begin
            ev_t got, want;
            got = ev(out_valid, pkt_done, err_parity, err_type,
                     out_valid ? out_word : 16'h0, out_valid ? out_type : 8'h0,
                     out_valid ? out_index : 4'h0);
            n_checks++;
            if (exp_q.size() == 0) begin
                n_errors++;
                $display("FAIL R2/R3/R4/R5/R6/R7/R8 unexpected event got %h expected none", got);
            end else begin
                want = exp_q.pop_front();
                if (got !== want) begin
                    n_errors++;
                    $display("FAIL R2/R4/R5/R6/R7 event got %h expected %h", got, want);
                end
            end
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] want);
        n_checks++;
        if (act !== want) begin
            n_errors++;
            $display("FAIL %s got %0h expected %0h", tag, act, want);
        end
    endtask

    task automatic send(input logic [15:0] w);
        in_valid = 1'b1;
        in_word  = w;
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic good_hit();
        if (exp_good < 65535) exp_good++;
    endtask

    // good packet; gap idle cycles between payload words
    task automatic pkt_good(input logic [7:0] t, input logic [3:0] n,
                            input logic [15:0] base, input int gap);
        send(mk_hdr(t, n));
        if (n == 0) begin
            exp_q.push_back(ev(1'b0, 1'b1, 1'b0, 1'b0, 16'h0, 8'h0, 4'h0));
        end
        for (int k = 0; k < int'(n); k++) begin
            exp_q.push_back(ev(1'b1, k == int'(n) - 1, 1'b0, 1'b0,
                               base + 16'(k), t, 4'(k)));
            send(base + 16'(k));
            idle(gap);
        end
        good_hit();
    endtask

    task automatic pulse_resync();
        resync = 1'b1;
        @(negedge clk);
        resync = 1'b0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_errors++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks + 1);
        $finish;
    end

    initial begin
        idle(3);
        // R1 reset state
        chk("R1 out_valid", 32'(out_valid), 0);
        chk("R1 pkt_done", 32'(pkt_done), 0);
        chk("R1 chan_reset_req", 32'(chan_reset_req), 0);
        chk("R1 errors", 32'({err_parity, err_type}), 0);
        chk("R1 good_count", 32'(good_count), 0);
        chk("R1 bad_count", 32'(bad_count), 0);
        rst_n = 1'b1;
        idle(2);

        // R5 R6 basic packet
        pkt_good(8'hA5, 4'd3, 16'h1230, 0);
        // R7 header-only
        pkt_good(8'hA5, 4'd0, 16'h0, 0);
        idle(2);
        chk("R6/R7 good_count", 32'(good_count), 32'(exp_good));

        // R3 filler then header
        send(16'h0000);
        send(16'h0000);
        pkt_good(8'hA5, 4'd2, 16'h7700, 0);
        idle(2);
        chk("R3 good_count", 32'(good_count), 32'(exp_good));
        chk("R3 bad_count", 32'(bad_count), 0);

        // R5 zero payload word delivered
        pkt_good(8'hA5, 4'd2, 16'h0000, 0);
        // R10 gaps
        pkt_good(8'hA5, 4'd3, 16'hBE00, 2);
        // R5 full-length packet
        pkt_good(8'hA5, 4'd15, 16'h4000, 0);
        idle(2);
        chk("R5/R10 good_count", 32'(good_count), 32'(exp_good));

        // R8 resync outside halt: no effect, mid-payload too
        pulse_resync();
        send(mk_hdr(8'hA5, 4'd2));
        exp_q.push_back(ev(1'b1, 1'b0, 1'b0, 1'b0, 16'h5550, 8'hA5, 4'd0));
        resync = 1'b1;
        send(16'h5550);
        resync = 1'b0;
        exp_q.push_back(ev(1'b1, 1'b1, 1'b0, 1'b0, 16'h5551, 8'hA5, 4'd1));
        send(16'h5551);
        good_hit();
        idle(2);
        chk("R8 resync ignored chan_reset_req", 32'(chan_reset_req), 0);
        chk("R8 resync ignored good_count", 32'(good_count), 32'(exp_good));

        // R2 parity fault
        exp_q.push_back(ev(1'b0, 1'b0, 1'b1, 1'b0, 16'h0, 8'h0, 4'h0));
        send(mk_hdr(8'hA5, 4'd2) ^ 16'h8000);
        exp_bad++;
        chk("R2 chan_reset_req", 32'(chan_reset_req), 1);
        chk("R2 bad_count", 32'(bad_count), 32'(exp_bad));
        // R8 input ignored while halted
        send(mk_hdr(8'hA5, 4'd0));
        send(mk_hdr(8'hA5, 4'd1));
        send(16'h1111);
        send(16'h8001);
        idle(2);
        chk("R8 halt held", 32'(chan_reset_req), 1);
        chk("R8 halt good_count", 32'(good_count), 32'(exp_good));
        chk("R8 halt bad_count", 32'(bad_count), 32'(exp_bad));
        pulse_resync();
        chk("R8 released", 32'(chan_reset_req), 0);
        pkt_good(8'hA5, 4'd1, 16'hC0DE, 0);

        // R4 type fault
        exp_q.push_back(ev(1'b0, 1'b0, 1'b0, 1'b1, 16'h0, 8'h0, 4'h0));
        send(mk_hdr(8'h3C, 4'd1));
        exp_bad++;
        chk("R4 chan_reset_req", 32'(chan_reset_req), 1);
        chk("R4 bad_count", 32'(bad_count), 32'(exp_bad));
        pulse_resync();

        // R2 both faults: parity reported
        exp_q.push_back(ev(1'b0, 1'b0, 1'b1, 1'b0, 16'h0, 8'h0, 4'h0));
        send(mk_hdr(8'h3C, 4'd1) ^ 16'h8000);
        exp_bad++;
        pulse_resync();

        // R4 other expected type accepted
        exp_type = 8'h3C;
        pkt_good(8'h3C, 4'd2, 16'h9990, 1);
        idle(2);
        chk("R4 bad_count", 32'(bad_count), 32'(exp_bad));
        chk("R6 good_count", 32'(good_count), 32'(exp_good));

        // R9 saturation of good_count
        for (int k = 0; k < 65540; k++) begin
            exp_q.push_back(ev(1'b0, 1'b1, 1'b0, 1'b0, 16'h0, 8'h0, 4'h0));
            send(mk_hdr(8'h3C, 4'd0));
            good_hit();
        end
        idle(3);
        chk("R9 good_count saturated", 32'(good_count), 32'd65535);
        chk("R9 bad_count", 32'(bad_count), 32'(exp_bad));
        chk("R5/R6 pending events", 32'(exp_q.size()), 0);

        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end
endmodule